// File: doc/BRIEF.md
# Serial Instruction/Scan Management Port

This block is a serial management port that runs on its own management clock and is gated by an active-low select line. While the port is selected it works in one of two modes. In instruction mode it shifts a command into an instruction register and, on the same clocks, shifts the current response out. In scan mode it connects the serial pins straight through to an internal scan string.

A transfer starts one clock after select goes low. In instruction mode, the captured command is presented in parallel one clock after select is released, together with a single-cycle execute strobe. On that execute cycle a fresh response is loaded in parallel from the response input, and the next instruction transfer shifts it out. The serial output is driven only while the port is in its shift state, and an output-enable tells the pad when to drive. A sticky flag records any instruction transfer that is followed too soon by a new select.

Top module: `mgmt_serial_port`

## Requirements
- R1: The shift state starts in the cycle after the first clock edge that samples `sel_n` low. `sdo_oe` is 1 in every shift cycle. It is 0 in the cycle after any edge that samples `sel_n` high, and `sdo` is 0 whenever `sdo_oe` is 0.
- R2: In mode 0 (instruction), each edge that samples `sel_n` low during the shift state shifts `sdi` into the instruction register, MSB first. In the cycle after the edge that samples `sel_n` high, `instr_o` holds the shifted word.
- R3: During a mode-0 transfer, `sdo` presents bit W-1-i of the response register before capture edge i. Bits past W read as 0. The response register is loaded from `resp_i` on the edge that ends the execute cycle, and it is 0 after reset.
- R4: A mode-0 transfer of n < W bits puts those bits in the n LSBs of `instr_o`, with zeros above them. A transfer of more than W bits keeps the last W bits.
- R5: In mode 1 (scan), while the port is shifting and `sel_n` is low, `scan_en` is 1, `scan_si` equals `sdi` and `sdo` equals `scan_so`. At all other times `scan_en` and `scan_si` are 0. Ending a scan transfer gives no execute pulse and leaves `instr_o` unchanged.
- R6: The mode is latched on the edge that starts the shift state. Changes to `mode` during the transfer have no effect on routing or on execution.
- R7: After a mode-0 transfer ends, `sel_n` must be sampled high on at least MIN_GAP consecutive edges (counting the ending edge; default 6). An earlier low sample sets `proto_err`, which stays set until reset. The transfer still proceeds.
- R8: After reset, no shift state or execute occurs until `sel_n` has been sampled high at least once. Reset clears `instr_o`, `exec_o`, `sdo_oe` and `proto_err`.
- R9: `exec_o` is high for exactly one cycle per completed mode-0 transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low port select |
| mode | input | 1 | 0 = instruction/status, 1 = scan |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the serial output pad |
| resp_i | input | W | Parallel response, loaded on the execute cycle |
| instr_o | output | W | Captured instruction |
| exec_o | output | 1 | One-cycle execute strobe |
| scan_si | output | 1 | Serial data toward the scan string |
| scan_so | input | 1 | Serial data from the scan string |
| scan_en | output | 1 | Scan string shift enable |
| proto_err | output | 1 | Sticky flag for a too-short deselect gap |

## Verification
A wrong shift-state register shows on `sdo_oe` and `scan_en` in the very next cycle. A wrong latched mode shows as scan routing inside an instruction transfer, or as a missing or extra execute strobe, one cycle after deselect. Errors in the instruction or response shift path show bit by bit on `sdo`, starting at the first capture. They also show as a mismatched `instr_o` when the execute strobe fires. A miscounted deselect gap shows as a wrong `proto_err` one cycle after the next select.

// File: rtl/msp_pkg.sv
package msp_pkg;
   typedef enum logic {
      MSP_MODE_INSTR = 1'b0,
      MSP_MODE_SCAN  = 1'b1
   } msp_mode_e;
endpackage

// File: rtl/msp_ctrl.sv
module msp_ctrl
   import msp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sel_n,
   input  logic      mode,
   output logic      shift_o,
   output msp_mode_e mode_o,
   output logic      start_o,
   output logic      cap_o,
   output logic      end0_o,
   output logic      idle_hi_o,
   output logic      exec_o
);
   logic      armed_q;
   logic      shift_q;
   msp_mode_e mode_q;
   logic      exec_q;

   // Start: idle, armed and select sampled low
   assign start_o   = !shift_q && armed_q && !sel_n;
   // Capture: inside shift state while still selected
   assign cap_o     = shift_q && !sel_n;
   // End of an instruction transfer: select released during shift state
   assign end0_o    = shift_q && sel_n && (mode_q == MSP_MODE_INSTR);
   assign idle_hi_o = !shift_q && sel_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         shift_q <= 1'b0;
         mode_q  <= MSP_MODE_INSTR;
         exec_q  <= 1'b0;
      end else begin
         exec_q <= end0_o;
         if (sel_n) begin
            armed_q <= 1'b1;
         end
         if (start_o) begin
            shift_q <= 1'b1;
            mode_q  <= msp_mode_e'(mode);
         end else if (shift_q && sel_n) begin
            shift_q <= 1'b0;
         end
      end
   end

   assign shift_o = shift_q;
   assign mode_o  = mode_q;
   assign exec_o  = exec_q;
endmodule

// File: rtl/msp_gap_mon.sv
module msp_gap_mon #(
   parameter int unsigned MIN_GAP = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic end0_i,
   input  logic idle_hi_i,
   input  logic start_i,
   output logic err_o
);
   localparam int unsigned GW = (MIN_GAP < 2) ? 1 : $clog2(MIN_GAP);

   generate
      if (MIN_GAP > 1) begin : g_count
         logic [GW-1:0] left_q;
         logic          err_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               left_q <= '0;
               err_q  <= 1'b0;
            end else begin
               if (end0_i) begin
                  left_q <= GW'(MIN_GAP - 1);
               end else if (idle_hi_i && (left_q != '0)) begin
                  left_q <= left_q - 1'b1;
               end else if (start_i) begin
                  left_q <= '0;
               end
               if (start_i && (left_q != '0)) begin
                  err_q <= 1'b1;
               end
            end
         end
         assign err_o = err_q;
      end else begin : g_none
         // A single ending edge already meets the gap
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ end0_i ^ idle_hi_i ^ start_i;
         assign err_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/msp_shreg.sv
module msp_shreg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         cap0_i,
   input  logic         end0_i,
   input  logic         load_i,
   input  logic         sdi,
   input  logic [W-1:0] resp_i,
   output logic [W-1:0] instr_o,
   output logic         resp_msb_o
);
   logic [W-1:0] in_sr_q;
   logic [W-1:0] out_sr_q;
   logic [W-1:0] instr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_sr_q  <= '0;
         out_sr_q <= '0;
         instr_q  <= '0;
      end else begin
         if (start_i) begin
            in_sr_q <= '0;
         end else if (cap0_i) begin
            in_sr_q <= {in_sr_q[W-2:0], sdi};
         end
         if (load_i) begin
            out_sr_q <= resp_i;
         end else if (cap0_i) begin
            out_sr_q <= {out_sr_q[W-2:0], 1'b0};
         end
         if (end0_i) begin
            instr_q <= in_sr_q;
         end
      end
   end

   assign instr_o    = instr_q;
   assign resp_msb_o = out_sr_q[W-1];
endmodule

// File: rtl/msp_route.sv
module msp_route
   import msp_pkg::*;
(
   input  logic      shift_i,
   input  msp_mode_e mode_i,
   input  logic      sel_n,
   input  logic      sdi,
   input  logic      resp_msb_i,
   input  logic      scan_so,
   output logic      sdo,
   output logic      sdo_oe,
   output logic      scan_si,
   output logic      scan_en
);
   logic scan_path;

   assign scan_path = shift_i && (mode_i == MSP_MODE_SCAN);

   always_comb begin
      sdo_oe  = shift_i;
      scan_en = scan_path && !sel_n;
      scan_si = scan_en ? sdi : 1'b0;
      if (!shift_i) begin
         sdo = 1'b0;
      end else if (scan_path) begin
         sdo = scan_so;
      end else begin
         sdo = resp_msb_i;
      end
   end
endmodule

// File: rtl/mgmt_serial_port.sv
module mgmt_serial_port
   import msp_pkg::*;
#(
   parameter int unsigned W       = 32,
   parameter int unsigned MIN_GAP = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sel_n,
   input  logic         mode,
   input  logic         sdi,
   output logic         sdo,
   output logic         sdo_oe,
   input  logic [W-1:0] resp_i,
   output logic [W-1:0] instr_o,
   output logic         exec_o,
   output logic         scan_si,
   input  logic         scan_so,
   output logic         scan_en,
   output logic         proto_err
);
   generate
      if (W < 2) begin : g_bad_w
         $error("mgmt_serial_port: W must be at least 2");
      end
      if (MIN_GAP < 1) begin : g_bad_gap
         $error("mgmt_serial_port: MIN_GAP must be at least 1");
      end
   endgenerate

   logic      shift_w;
   msp_mode_e mode_w;
   logic      start_w;
   logic      cap_w;
   logic      end0_w;
   logic      idle_hi_w;
   logic      exec_w;
   logic      cap0_w;
   logic      resp_msb_w;

   msp_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_n     (sel_n),
      .mode      (mode),
      .shift_o   (shift_w),
      .mode_o    (mode_w),
      .start_o   (start_w),
      .cap_o     (cap_w),
      .end0_o    (end0_w),
      .idle_hi_o (idle_hi_w),
      .exec_o    (exec_w)
   );

   assign cap0_w = cap_w && (mode_w == MSP_MODE_INSTR);

   msp_shreg #(.W(W)) u_shreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_w),
      .cap0_i     (cap0_w),
      .end0_i     (end0_w),
      .load_i     (exec_w),
      .sdi        (sdi),
      .resp_i     (resp_i),
      .instr_o    (instr_o),
      .resp_msb_o (resp_msb_w)
   );

   msp_gap_mon #(.MIN_GAP(MIN_GAP)) u_gap (
      .clk       (clk),
      .rst_n     (rst_n),
      .end0_i    (end0_w),
      .idle_hi_i (idle_hi_w),
      .start_i   (start_w),
      .err_o     (proto_err)
   );

   msp_route u_route (
      .shift_i    (shift_w),
      .mode_i     (mode_w),
      .sel_n      (sel_n),
      .sdi        (sdi),
      .resp_msb_i (resp_msb_w),
      .scan_so    (scan_so),
      .sdo        (sdo),
      .sdo_oe     (sdo_oe),
      .scan_si    (scan_si),
      .scan_en    (scan_en)
   );

   assign exec_o = exec_w;
endmodule

// File: rtl/msp_checker.sv
module msp_checker (
   input logic clk,
   input logic rst_n,
   input logic sel_n,
   input logic sdo,
   input logic sdo_oe,
   input logic scan_en,
   input logic exec_o,
   input logic proto_err
);
   a_r1_release_tristates: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |=> !sdo_oe);
   a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe |-> !sdo);
   a_r1_enable_after_select: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> $past(!sel_n));
   a_r5_scan_inside_shift: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |-> (sdo_oe && !sel_n));
   a_r9_exec_single: assert property (@(posedge clk) disable iff (!rst_n)
      exec_o |=> !exec_o);
   a_r2_exec_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      exec_o |-> ($past(sel_n) && !sdo_oe));
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);
endmodule

bind mgmt_serial_port msp_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel_n     (sel_n),
   .sdo       (sdo),
   .sdo_oe    (sdo_oe),
   .scan_en   (scan_en),
   .exec_o    (exec_o),
   .proto_err (proto_err)
);

// File: tb/mgmt_serial_port_test.sv
module mgmt_serial_port_test;
   localparam int W       = 32;
   localparam int MIN_GAP = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sel_n = 1'b0;
   logic         mode = 1'b0;
   logic         sdi = 1'b0;
   logic         sdo;
   logic         sdo_oe;
   logic [W-1:0] resp_i = '0;
   logic [W-1:0] instr_o;
   logic         exec_o;
   logic         scan_si;
   logic         scan_so = 1'b0;
   logic         scan_en;
   logic         proto_err;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [W-1:0] m_resp  = '0;
   logic [W-1:0] m_instr = '0;
   bit           m_err   = 1'b0;
   bit           last_m0 = 1'b0;
   int           last_gap = 100;

   mgmt_serial_port #(.W(W), .MIN_GAP(MIN_GAP)) uut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .mode(mode), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .resp_i(resp_i), .instr_o(instr_o),
      .exec_o(exec_o), .scan_si(scan_si), .scan_so(scan_so),
      .scan_en(scan_en), .proto_err(proto_err)
   );

   always #2 clk = ~clk;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_resp_bit(input logic [W-1:0] r, input int i);
      return (i < W) ? r[W-1-i] : 1'b0;
   endfunction

   function automatic logic [W-1:0] shift_in(input logic [W-1:0] a, input logic b);
      return {a[W-2:0], b};
   endfunction

   // One transfer; gap = edges sampling sel_n high before the next start (>=3)
   task automatic xfer(input bit m, input int n, input logic [63:0] bits,
                       input int gap, input bit flip);
      logic [W-1:0] acc = '0;
      logic         so_b;
      if (last_m0 && last_gap < MIN_GAP) m_err = 1'b1;
      @(negedge clk);
      sel_n = 1'b0;
      mode  = m;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (flip && i == 1) mode = ~m;
         sdi     = bits[n-1-i];
         so_b    = 1'($urandom);
         scan_so = so_b;
         #1;
         check("R1 oe in shift", 64'(sdo_oe), 64'd1);
         if (!m) begin
            check("R3 sdo resp bit", 64'(sdo), 64'(exp_resp_bit(m_resp, i)));
            check("R6 no scan in mode0", 64'(scan_en), 64'd0);
            acc = shift_in(acc, sdi);
         end else begin
            check("R5 scan_en", 64'(scan_en), 64'd1);
            check("R5 scan_si", 64'(scan_si), 64'(sdi));
            check("R5 sdo from chain", 64'(sdo), 64'(so_b));
         end
      end
      @(negedge clk);
      sel_n  = 1'b1;
      resp_i = W'($urandom);
      #1;
      check("R5 scan_en off after release", 64'(scan_en), 64'd0);
      @(negedge clk);
      #1;
      check("R1 oe off", 64'(sdo_oe), 64'd0);
      check("R1 sdo quiet", 64'(sdo), 64'd0);
      if (!m) begin
         check("R9 exec high", 64'(exec_o), 64'd1);
         m_instr = acc;
         m_resp  = resp_i;
         check(n < W ? "R4 short instr" : "R2 instr", 64'(instr_o), 64'(m_instr));
      end else begin
         check("R5 no exec", 64'(exec_o), 64'd0);
         check("R5 instr kept", 64'(instr_o), 64'(m_instr));
      end
      @(negedge clk);
      check("R9 exec one cycle", 64'(exec_o), 64'd0);
      check("R7 err flag", 64'(proto_err), 64'(m_err));
      repeat (gap - 3) @(negedge clk);
      last_m0  = !m;
      last_gap = gap;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      check("R8 reset oe", 64'(sdo_oe), 64'd0);
      check("R8 reset exec", 64'(exec_o), 64'd0);
      check("R8 reset instr", 64'(instr_o), 64'd0);
      check("R8 reset err", 64'(proto_err), 64'd0);
      rst_n = 1'b1;
      repeat (4) begin
         @(negedge clk);
         check("R8 not armed", 64'(sdo_oe), 64'd0);
      end
      sel_n = 1'b1;
      repeat (3) @(negedge clk);
      // directed cases
      xfer(1'b0, W, 64'hA5C3_0F96, 8, 1'b0);
      xfer(1'b0, 5, 64'h15, 7, 1'b0);
      xfer(1'b0, W + 3, 64'h5_1234_5678, 6, 1'b0);
      xfer(1'b1, 9, 64'h1AB, 4, 1'b0);
      xfer(1'b0, 12, 64'hABC, 6, 1'b1);
      xfer(1'b1, 6, 64'h2D, 6, 1'b1);
      // random phase with legal gaps
      for (int k = 0; k < 40; k++) begin
         xfer(1'($urandom), 1 + int'($urandom_range(W + 3)),
              {$urandom, $urandom}, MIN_GAP + int'($urandom_range(4)), 1'($urandom));
      end
      // gap violation after an instruction transfer, then stickiness
      xfer(1'b0, 8, 64'h3C, 4, 1'b0);
      xfer(1'b0, 8, 64'hC3, 9, 1'b0);
      xfer(1'b1, 4, 64'h9, 9, 1'b0);
      check("R7 sticky", 64'(proto_err), 64'd1);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule